// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block is a serial slave port that lets an external host read and write a bank of 128 byte-wide configuration registers. The host selects the port with an active-low select line. On each rising edge of the serial clock the host shifts one bit in. Every transfer opens with an 8-bit command byte that carries a direction flag and a 7-bit register address. After the command come one or more data bytes. For a stream of several data bytes, the address steps automatically from one byte to the next.

The serial pins are sampled in the system clock domain, so the system clock must run several times faster than the serial clock. Register 0x00 controls the port itself. Its bit 6 selects least-significant-bit-first order, and its bit 7 selects 3-wire operation, in which read data leaves on the shared data pin. The data pin outputs are presented as separate value and enable signals, ready for a tristate pad.

Top module: `spi_reg_slave`

## Requirements
- R1: The first eight bits after select goes low form the command byte. Command bit 7 = 1 means read and 0 means write. Command bits 6..0 hold the starting register address.
- R2: Input bits are taken on rising serial-clock edges and output bits change after falling edges. The first read bit is presented after the falling edge that follows the eighth rising edge.
- R3: With register 0x00 bit 6 = 0, bits travel most significant first and the address decrements after each data byte, wrapping from 0x00 to 0x7F.
- R4: With register 0x00 bit 6 = 1, the command and data bytes travel least significant first and the address increments after each data byte.
- R5: Each written byte is stored as soon as its eighth bit arrives. A byte cut short by select going high is discarded.
- R6: Raising select returns the port to the command phase from any state, and the next transfer works normally.
- R7: With register 0x00 bit 7 = 0, read data appears on the separate output pin and the shared data pin is never driven. With bit 7 = 1, read data appears on the shared data pin and the separate output stays undriven.
- R8: Neither output enable is active while select is high or during a write transfer.
- R9: A change to register 0x00 bits 6 and 7 takes effect from the next transfer. The remaining bytes of the current transfer keep the old setting.
- R10: After reset, every register reads as 0x00 and both output enables are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_sdio_in | input | 1 | Input value of the shared data pin |
| spi_sdio_out | output | 1 | Output value for the shared data pin |
| spi_sdio_oe | output | 1 | Drive enable for the shared data pin (3-wire reads) |
| spi_sdo_out | output | 1 | Output value for the separate data-out pin |
| spi_sdo_oe | output | 1 | Drive enable for the separate data-out pin (4-wire reads) |

## Verification
The embedded assertions check several properties on every system clock:
- read and write strobes into the register bank never coincide;
- a deselected port is back in the command phase with its bit counter cleared;
- the mode bits stay frozen while a transfer is open;
- an output enable is active only in the data phase of a read;
- the address steps by exactly one, in the direction the bit order sets, at each data-byte boundary.

The following can only be shown by the directed scenarios, which read the results back through the port:
- the stored values themselves;
- the decrement wrap;
- the discarding of a truncated byte;
- the delayed effect of a mode change;
- the pin on which read data actually appears.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int CTRL_REG = 0;
  localparam int LSB_BIT  = 6;
  localparam int WIRE_BIT = 7;

  typedef struct packed {
    logic three_wire;
    logic lsb_first;
  } port_cfg_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= rst_val;
      cur_o  <= rst_val;
      prev_o <= rst_val;
    end else begin
      meta_q <= pin_i;
      cur_o  <= meta_q;
      prev_o <= cur_o;
    end
  end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_reg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output port_cfg_t     cfg_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] written_q;
  logic [DW-1:0]    raw_q;
  logic             hit_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) raw_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      hit_q     <= 1'b0;
      cfg_o     <= '0;
    end else begin
      if (wr_en) begin
        written_q[wr_addr] <= 1'b1;
        if (wr_addr == AW'(CTRL_REG)) begin
          cfg_o.three_wire <= wr_data[WIRE_BIT];
          cfg_o.lsb_first  <= wr_data[LSB_BIT];
        end
      end
      if (rd_en) hit_q <= written_q[rd_addr];
    end
  end

  assign rd_data = hit_q ? raw_q : '0;

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en)); // R1
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_reg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_cur,
  input  logic          sclk_prev,
  input  logic          cs_cur,
  input  logic          din,
  input  port_cfg_t     cfg_i,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          bit_out,
  output logic          sdo_oe_q,
  output logic          sdio_oe_q
);
  localparam int CW = $clog2(DW);

  logic          rise, fall, active, last_bit;
  logic [CW-1:0] bit_cnt;
  logic          cmd_phase, rw_q, ld_q;
  logic          lsb_q, three_q;
  logic [AW-1:0] addr_q, addr_step;
  logic [DW-1:0] shin_q, shin_nx, tx_q;

  assign rise     = sclk_cur & ~sclk_prev;
  assign fall     = ~sclk_cur & sclk_prev;
  assign active   = ~cs_cur;
  assign last_bit = (bit_cnt == CW'(DW - 1));

  always_comb begin
    shin_nx   = lsb_q ? {din, shin_q[DW-1:1]} : {shin_q[DW-2:0], din};
    addr_step = lsb_q ? addr_q + AW'(1) : addr_q - AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      cmd_phase <= 1'b1;
      rw_q      <= 1'b0;
      ld_q      <= 1'b0;
      lsb_q     <= 1'b0;
      three_q   <= 1'b0;
      addr_q    <= '0;
      shin_q    <= '0;
      tx_q      <= '0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      bit_out   <= 1'b0;
      sdo_oe_q  <= 1'b0;
      sdio_oe_q <= 1'b0;
    end else begin
      rd_en <= 1'b0;
      wr_en <= 1'b0;
      ld_q  <= rd_en;
      if (ld_q) tx_q <= rd_data;
      if (!active) begin
        bit_cnt   <= '0;
        cmd_phase <= 1'b1;
        rw_q      <= 1'b0;
        sdo_oe_q  <= 1'b0;
        sdio_oe_q <= 1'b0;
        lsb_q     <= cfg_i.lsb_first;
        three_q   <= cfg_i.three_wire;
      end else begin
        if (rise) begin
          shin_q  <= shin_nx;
          bit_cnt <= bit_cnt + CW'(1);
          if (last_bit) begin
            if (cmd_phase) begin
              cmd_phase <= 1'b0;
              rw_q      <= shin_nx[DW-1];
              addr_q    <= shin_nx[AW-1:0];
              rd_en     <= shin_nx[DW-1];
              rd_addr   <= shin_nx[AW-1:0];
            end else begin
              addr_q <= addr_step;
              if (rw_q) begin
                rd_en   <= 1'b1;
                rd_addr <= addr_step;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= addr_q;
                wr_data <= shin_nx;
              end
            end
          end
        end
        if (fall && !cmd_phase && rw_q) begin
          bit_out   <= lsb_q ? tx_q[0] : tx_q[DW-1];
          tx_q      <= lsb_q ? (tx_q >> 1) : (tx_q << 1);
          sdo_oe_q  <= ~three_q;
          sdio_oe_q <= three_q;
        end
      end
    end
  end

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_cur |=> (bit_cnt == '0) && cmd_phase); // R6
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> ($stable(lsb_q) && $stable(three_q))); // R9
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe_q || sdio_oe_q) |-> (rw_q && !cmd_phase)); // R8
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    !(sdo_oe_q && sdio_oe_q)); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (active && rise && last_bit && !cmd_phase) |=>
      (addr_q == ($past(lsb_q) ? $past(addr_q) + AW'(1) : $past(addr_q) - AW'(1)))); // R3
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_sdio_in,
  output logic spi_sdio_out,
  output logic spi_sdio_oe,
  output logic spi_sdo_out,
  output logic spi_sdo_oe
);
  logic [2:0]    pin_cur, pin_prev;
  logic          rd_en, wr_en, bit_out, sdo_oe_q, sdio_oe_q;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  port_cfg_t     cfg;

  spi_pin_sync #(.W(3)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  ({spi_cs_n, spi_sclk, spi_sdio_in}),
    .rst_val(3'b100),
    .cur_o  (pin_cur),
    .prev_o (pin_prev)
  );

  spi_shift_engine #(.AW(AW), .DW(DW)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .sclk_cur (pin_cur[1]),
    .sclk_prev(pin_prev[1]),
    .cs_cur   (pin_cur[2]),
    .din      (pin_cur[0]),
    .cfg_i    (cfg),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .bit_out  (bit_out),
    .sdo_oe_q (sdo_oe_q),
    .sdio_oe_q(sdio_oe_q)
  );

  spi_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .cfg_o  (cfg)
  );

  // pad-side gating: release both pins the moment select rises
  assign spi_sdio_out = bit_out;
  assign spi_sdo_out  = bit_out;
  assign spi_sdio_oe  = sdio_oe_q & ~spi_cs_n;
  assign spi_sdo_oe   = sdo_oe_q & ~spi_cs_n;
endmodule

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;
  localparam int HP = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdio_out, sdio_oe, sdo_out, sdo_oe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit tb_lsb = 1'b0;
  bit tb_three = 1'b0;
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];
  bit oe_bad;

  always #5 clk = ~clk;

  spi_reg_slave u_dut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_sdio_in(sdi), .spi_sdio_out(sdio_out), .spi_sdio_oe(sdio_oe),
    .spi_sdo_out(sdo_out), .spi_sdo_oe(sdo_oe)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    wait_clk(HP);
    sclk = 1'b1;
    wait_clk(HP);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input int nbits);
    for (int i = 0; i < nbits; i++) send_bit(tb_lsb ? v[i] : v[7-i]);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      wait_clk(HP);
      if (tb_three) begin
        if (!sdio_oe || sdo_oe) oe_bad = 1'b1;
        v[tb_lsb ? i : 7-i] = sdio_out;
      end else begin
        if (!sdo_oe || sdio_oe) oe_bad = 1'b1;
        v[tb_lsb ? i : 7-i] = sdo_out;
      end
      sclk = 1'b1;
      wait_clk(HP);
      sclk = 1'b0;
    end
  endtask

  // one transfer: nbytes whole data bytes, then extra_bits of wbuf[nbytes]
  task automatic xfer(input bit rd, input logic [6:0] a, input int nbytes, input int extra_bits);
    oe_bad = 1'b0;
    cs_n = 1'b0;
    wait_clk(HP);
    send_byte({rd, a}, 8);
    for (int b = 0; b < nbytes; b++) begin
      if (rd) recv_byte(rbuf[b]);
      else begin
        send_byte(wbuf[b], 8);
        if (sdio_oe || sdo_oe) oe_bad = 1'b1;
      end
    end
    if (extra_bits > 0) send_byte(wbuf[nbytes], extra_bits);
    wait_clk(HP);
    cs_n = 1'b1;
    wait_clk(1);
    if (sdio_oe || sdo_oe) oe_bad = 1'b1;
    wait_clk(2 * HP);
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d);
    wbuf[0] = d;
    xfer(1'b0, a, 1, 0);
  endtask

  task automatic rd_check(input string req, input logic [6:0] a, input logic [7:0] exp);
    xfer(1'b1, a, 1, 0);
    check(req, rbuf[0], exp);
  endtask

  task automatic t_reset;
    check("R10 sdio_oe after reset", sdio_oe, 0);
    check("R10 sdo_oe after reset", sdo_oe, 0);
    rd_check("R10 reg 0x05 reset value", 7'h05, 8'h00);
    rd_check("R10 reg 0x7F reset value", 7'h7F, 8'h00);
  endtask

  task automatic t_basic;
    wr1(7'h10, 8'hA5);
    check("R8 no enable during write/deselect", oe_bad, 0);
    xfer(1'b1, 7'h10, 1, 0);
    check("R1 R2 read back 0x10", rbuf[0], 8'hA5);
    check("R7 4-wire pin use on read", oe_bad, 0);
  endtask

  task automatic t_msb_stream;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    xfer(1'b0, 7'h22, 3, 0);
    rd_check("R3 decrement first byte at 0x22", 7'h22, 8'h11);
    rd_check("R3 decrement second byte at 0x21", 7'h21, 8'h22);
    rd_check("R3 decrement third byte at 0x20", 7'h20, 8'h33);
    xfer(1'b1, 7'h22, 3, 0);
    check("R3 stream read 0x22", rbuf[0], 8'h11);
    check("R3 stream read 0x21", rbuf[1], 8'h22);
    check("R3 stream read 0x20", rbuf[2], 8'h33);
    wr1(7'h7F, 8'h5C);
    xfer(1'b1, 7'h00, 2, 0);
    check("R3 wrap read 0x00", rbuf[0], 8'h00);
    check("R3 wrap read 0x7F", rbuf[1], 8'h5C);
  endtask

  task automatic t_abort;
    wbuf[0] = 8'h66; wbuf[1] = 8'h77; wbuf[2] = 8'h88;
    xfer(1'b0, 7'h30, 2, 5);
    rd_check("R5 committed byte 0x30", 7'h30, 8'h66);
    rd_check("R5 committed byte 0x2F", 7'h2F, 8'h77);
    rd_check("R5 truncated byte not stored 0x2E", 7'h2E, 8'h00);
    cs_n = 1'b0;
    wait_clk(HP);
    send_byte(8'h45, 3);
    cs_n = 1'b1;
    wait_clk(2 * HP);
    wr1(7'h45, 8'h9E);
    rd_check("R6 transfer after cut-off command", 7'h45, 8'h9E);
  endtask

  task automatic t_lsb;
    wbuf[0] = 8'h40; wbuf[1] = 8'h3C;
    xfer(1'b0, 7'h00, 2, 0);
    tb_lsb = 1'b1;
    rd_check("R9 byte after mode write kept old order", 7'h7F, 8'h3C);
    wbuf[0] = 8'hC1; wbuf[1] = 8'h12;
    xfer(1'b0, 7'h50, 2, 0);
    xfer(1'b1, 7'h50, 2, 0);
    check("R4 lsb-first increment 0x50", rbuf[0], 8'hC1);
    check("R4 lsb-first increment 0x51", rbuf[1], 8'h12);
    wr1(7'h00, 8'h00);
    tb_lsb = 1'b0;
    rd_check("R4 back to msb-first read 0x10", 7'h10, 8'hA5);
  endtask

  task automatic t_three;
    wr1(7'h00, 8'h80);
    tb_three = 1'b1;
    xfer(1'b1, 7'h10, 1, 0);
    check("R7 3-wire read on sdio", rbuf[0], 8'hA5);
    check("R7 3-wire sdo stays released", oe_bad, 0);
    wr1(7'h00, 8'h00);
    tb_three = 1'b0;
    xfer(1'b1, 7'h21, 1, 0);
    check("R7 4-wire restored read", rbuf[0], 8'h22);
    check("R8 enables idle after transfers", {sdio_oe, sdo_oe}, 2'b00);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_basic();
    t_msb_stream();
    t_abort();
    t_lsb();
    t_three();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule